// File: doc/BRIEF.md
# CPU Activity State Controller

This block keeps track of whether a processor core is running, halted, sleeping in one of two monitor-wait flavours, or parked until a startup message arrives. The execution unit sends it requests to halt, to enter monitor-wait, or to park. The controller then watches the pending-event lines and the interrupt-enable flag, and decides when a sleeping core may resume. When that happens it gives a one-cycle wake pulse. The core uses that pulse to resume fetching and to clear its interrupt-inhibit shadow.

A parked core does not respond to interrupts or system events. Only a startup message releases it. That message carries an 8-bit vector. The controller turns the vector into a new code-segment base, which is the vector shifted left by eight bits, and zeroes the instruction pointer. It also clears the event masks that were set when the core parked.

When a core leaves either monitor-wait state, the controller also pulses a monitor-reset line so that the address monitor is disarmed.

Top module: `cpu_activity_ctrl`

## Requirements
- R1: After reset the state is ACTIVE (code 0), the event masks are 0, the wake, monitor-reset and start-load pulses are 0, `cs_base_o` equals RESET_CS and `ip_o` equals RESET_IP.
- R2: The state codes are ACTIVE=0, HLT=1, PARKED=2, MWAIT=3 and MWAIT_IF=4. In ACTIVE, a park request moves to PARKED, otherwise a halt request moves to HLT, otherwise a monitor-wait request moves to MWAIT_IF when `mwait_ign_if` is 1 and to MWAIT when it is 0. The state changes one cycle after the request.
- R3: Halt, monitor-wait and park requests that arrive while the state is not ACTIVE have no effect.
- R4: In HLT or MWAIT, a pending maskable interrupt (`intr_pend`) or local-controller interrupt (`lapic_pend`) wakes the core only when `if_flag` is 1.
- R5: In MWAIT_IF, a pending maskable or local-controller interrupt wakes the core even when `if_flag` is 0.
- R6: In HLT, MWAIT or MWAIT_IF, a pending NMI, SMI or INIT wakes the core whatever the value of `if_flag`.
- R7: On a wake, the state is ACTIVE one cycle after the wake condition, and `wake_o` is high for exactly that one cycle.
- R8: `mon_reset_o` pulses together with `wake_o` only when the core wakes from MWAIT or MWAIT_IF. It stays 0 when the core wakes from HLT.
- R9: In PARKED, no combination of pending interrupt, NMI, SMI or INIT changes the state or raises `wake_o`.
- R10: A startup message (`sipi_valid`) in PARKED sets, one cycle later, the state to ACTIVE, `ip_o` to 0, `cs_base_o` to the vector times 0x100, and the event masks to 0. It also pulses `start_load_o` for one cycle and leaves `wake_o` low.
- R11: A startup message in any state other than PARKED changes neither `cs_base_o`, `ip_o`, the state nor `start_load_o`.
- R12: Entering PARKED sets all event mask bits to 1. In `evt_mask_o`, bit 0 is NMI, bit 1 is SMI and bit 2 is INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Request to enter HLT |
| mwait_req | input | 1 | Request to enter monitor-wait |
| mwait_ign_if | input | 1 | Monitor-wait variant that wakes on interrupts with IF=0 |
| park_req | input | 1 | Request to park until a startup message |
| intr_pend | input | 1 | Maskable interrupt pending |
| lapic_pend | input | 1 | Local-controller interrupt pending |
| nmi_pend | input | 1 | NMI pending |
| smi_pend | input | 1 | SMI pending |
| init_pend | input | 1 | INIT pending |
| if_flag | input | 1 | Interrupt-enable flag |
| sipi_valid | input | 1 | Startup message strobe |
| sipi_vector | input | VEC_W | Startup message vector |
| state_o | output | 3 | Current activity state code |
| wake_o | output | 1 | One-cycle wake pulse; the core also clears its inhibit shadow on it |
| mon_reset_o | output | 1 | One-cycle monitor disarm pulse |
| start_load_o | output | 1 | One-cycle pulse when a startup message is taken |
| cs_base_o | output | CS_W | Code-segment base |
| ip_o | output | IP_W | Instruction pointer |
| evt_mask_o | output | 3 | Event masks: bit 0 NMI, bit 1 SMI, bit 2 INIT |

## Verification
The bench targets the state-dependent interrupt gating. A maskable interrupt with IF=0 must leave HLT and MWAIT asleep but must wake MWAIT_IF. A design that handled the two monitor variants alike would fail one of those vectors.

It also drives every event together, with IF set, into a parked core. A controller that did not treat PARKED specially would wake there.

Further cases cover:
- startup messages sent to a core that is not parked, which a careless design would use to corrupt the code-segment base;
- vectors 0x00 and 0xFF, which catch a wrong shift or truncation;
- requests that arrive while the core is already asleep;
- a monitor-reset that would wrongly pulse on a wake from HLT.

// File: rtl/act_pkg.sv
package act_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_HALT   = 3'd1,
    ST_PARK   = 3'd2,
    ST_MON    = 3'd3,
    ST_MON_IF = 3'd4
  } act_state_e;

  localparam int MASK_W = 3;

  // Both monitor-wait states sit at or above ST_MON.
  function automatic logic is_monitor(act_state_e s);
    return s >= ST_MON;
  endfunction

  function automatic logic is_sleeping(act_state_e s);
    return (s == ST_HALT) || is_monitor(s);
  endfunction
endpackage

// File: rtl/act_wake_eval.sv
module act_wake_eval
  import act_pkg::*;
(
  input  act_state_e state,
  input  logic       intr_pend,
  input  logic       lapic_pend,
  input  logic       nmi_pend,
  input  logic       smi_pend,
  input  logic       init_pend,
  input  logic       if_flag,
  output logic       wake_maskable,
  output logic       wake_system,
  output logic       wake
);
  logic irq_any;
  logic irq_gate;

  always_comb begin
    irq_any       = intr_pend | lapic_pend;
    irq_gate      = if_flag | (state == ST_MON_IF);
    wake_maskable = is_sleeping(state) & irq_any & irq_gate;
    wake_system   = is_sleeping(state) & (nmi_pend | smi_pend | init_pend);
    wake          = wake_maskable | wake_system;
  end
endmodule

// File: rtl/act_fsm.sv
module act_fsm
  import act_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_req,
  input  logic              mwait_req,
  input  logic              mwait_ign_if,
  input  logic              park_req,
  input  logic              wake,
  input  logic              sipi_valid,
  output act_state_e        state,
  output logic              wake_q,
  output logic              mon_rst_q,
  output logic              sipi_take,
  output logic [MASK_W-1:0] mask_q
);
  assign sipi_take = (state == ST_PARK) & sipi_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      wake_q    <= 1'b0;
      mon_rst_q <= 1'b0;
      mask_q    <= '0;
    end else begin
      wake_q    <= 1'b0;
      mon_rst_q <= 1'b0;
      case (state)
        ST_RUN: begin
          if (park_req) begin
            state  <= ST_PARK;
            mask_q <= '1;
          end else if (halt_req) begin
            state <= ST_HALT;
          end else if (mwait_req) begin
            state <= mwait_ign_if ? ST_MON_IF : ST_MON;
          end
        end
        ST_PARK: begin
          if (sipi_valid) begin
            state  <= ST_RUN;
            mask_q <= '0;
          end
        end
        default: begin
          if (wake) begin
            state     <= ST_RUN;
            wake_q    <= 1'b1;
            mon_rst_q <= is_monitor(state);
          end
        end
      endcase
    end
  end

  // R9: a parked core stays parked until a startup message
  a_r9_park_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PARK && !sipi_valid) |=> (state == ST_PARK));
  // R3: sleeping states ignore new requests when no wake is due
  a_r3_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sleeping(state) && !wake) |=> $stable(state));
  // R7: wake pulse lasts one cycle and lands in ACTIVE
  a_r7_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> (state == ST_RUN) ##1 !wake_q);
  // R8: monitor reset only accompanies a wake from a monitor state
  a_r8_mr_source: assert property (@(posedge clk) disable iff (!rst_n)
    mon_rst_q |-> (wake_q && is_monitor($past(state))));
endmodule

// File: rtl/act_start_load.sv
module act_start_load #(
  parameter int          VEC_W    = 8,
  parameter int          CS_W     = 32,
  parameter int          IP_W     = 32,
  parameter int          SHIFT    = 8,
  parameter logic [31:0] RESET_CS = 32'hFFFF_0000,
  parameter logic [31:0] RESET_IP = 32'h0000_FFF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sipi_take,
  input  logic [VEC_W-1:0] vector,
  output logic [CS_W-1:0]  cs_base,
  output logic [IP_W-1:0]  ip,
  output logic             start_q
);
  function automatic logic [CS_W-1:0] vec_to_base(logic [VEC_W-1:0] v);
    return CS_W'(v) << SHIFT;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_base <= RESET_CS[CS_W-1:0];
      ip      <= RESET_IP[IP_W-1:0];
      start_q <= 1'b0;
    end else begin
      start_q <= sipi_take;
      if (sipi_take) begin
        cs_base <= vec_to_base(vector);
        ip      <= '0;
      end
    end
  end

  // R10: a taken startup message leaves the pointer at zero
  a_r10_ip_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (ip == '0));
  // R11: without a taken message the base does not move
  a_r11_base_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !sipi_take |=> $stable(cs_base));
endmodule

// File: rtl/cpu_activity_ctrl.sv
module cpu_activity_ctrl
  import act_pkg::*;
#(
  parameter int          VEC_W    = 8,
  parameter int          CS_W     = 32,
  parameter int          IP_W     = 32,
  parameter logic [31:0] RESET_CS = 32'hFFFF_0000,
  parameter logic [31:0] RESET_IP = 32'h0000_FFF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req,
  input  logic             mwait_req,
  input  logic             mwait_ign_if,
  input  logic             park_req,
  input  logic             intr_pend,
  input  logic             lapic_pend,
  input  logic             nmi_pend,
  input  logic             smi_pend,
  input  logic             init_pend,
  input  logic             if_flag,
  input  logic             sipi_valid,
  input  logic [VEC_W-1:0] sipi_vector,
  output logic [2:0]       state_o,
  output logic             wake_o,
  output logic             mon_reset_o,
  output logic             start_load_o,
  output logic [CS_W-1:0]  cs_base_o,
  output logic [IP_W-1:0]  ip_o,
  output logic [2:0]       evt_mask_o
);
  act_state_e        state;
  logic              wake;
  logic              wake_maskable;
  logic              wake_system;
  logic              sipi_take;
  logic [MASK_W-1:0] mask_q;

  act_wake_eval u_eval (
    .state        (state),
    .intr_pend    (intr_pend),
    .lapic_pend   (lapic_pend),
    .nmi_pend     (nmi_pend),
    .smi_pend     (smi_pend),
    .init_pend    (init_pend),
    .if_flag      (if_flag),
    .wake_maskable(wake_maskable),
    .wake_system  (wake_system),
    .wake         (wake)
  );

  act_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_req    (halt_req),
    .mwait_req   (mwait_req),
    .mwait_ign_if(mwait_ign_if),
    .park_req    (park_req),
    .wake        (wake),
    .sipi_valid  (sipi_valid),
    .state       (state),
    .wake_q      (wake_o),
    .mon_rst_q   (mon_reset_o),
    .sipi_take   (sipi_take),
    .mask_q      (mask_q)
  );

  act_start_load #(
    .VEC_W   (VEC_W),
    .CS_W    (CS_W),
    .IP_W    (IP_W),
    .RESET_CS(RESET_CS),
    .RESET_IP(RESET_IP)
  ) u_load (
    .clk      (clk),
    .rst_n    (rst_n),
    .sipi_take(sipi_take),
    .vector   (sipi_vector),
    .cs_base  (cs_base_o),
    .ip       (ip_o),
    .start_q  (start_load_o)
  );

  assign state_o    = state;
  assign evt_mask_o = mask_q;

  // R6: system events wake any sleeping state
  a_r6_system_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sleeping(state) && (nmi_pend || smi_pend || init_pend)) |=> wake_o);
  // R4: HLT and MWAIT stay asleep on interrupts while IF is clear
  a_r4_if_gates: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_HALT || state == ST_MON) && !if_flag &&
     !(nmi_pend || smi_pend || init_pend)) |=> !wake_o);
  // R5: the IF-ignoring monitor variant wakes on an interrupt
  a_r5_mon_if_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MON_IF && (intr_pend || lapic_pend)) |=> wake_o);
  // R10: a startup load never coincides with a wake pulse
  a_r10_no_wake_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    start_load_o |-> !wake_o);
endmodule

// File: tb/tb_cpu_activity_ctrl.sv
`timescale 1ns/1ps
module tb_cpu_activity_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt_req = 0, mwait_req = 0, mwait_ign_if = 0, park_req = 0;
  logic        intr_pend = 0, lapic_pend = 0, nmi_pend = 0, smi_pend = 0, init_pend = 0;
  logic        if_flag = 0, sipi_valid = 0;
  logic [7:0]  sipi_vector = 0;
  logic [2:0]  state_o;
  logic        wake_o, mon_reset_o, start_load_o;
  logic [31:0] cs_base_o, ip_o;
  logic [2:0]  evt_mask_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_cs = 32'hFFFF_0000;
  logic [31:0] exp_ip = 32'h0000_FFF0;

  always #2 clk = ~clk;

  cpu_activity_ctrl dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .mwait_req(mwait_req),
    .mwait_ign_if(mwait_ign_if), .park_req(park_req), .intr_pend(intr_pend),
    .lapic_pend(lapic_pend), .nmi_pend(nmi_pend), .smi_pend(smi_pend),
    .init_pend(init_pend), .if_flag(if_flag), .sipi_valid(sipi_valid),
    .sipi_vector(sipi_vector), .state_o(state_o), .wake_o(wake_o),
    .mon_reset_o(mon_reset_o), .start_load_o(start_load_o),
    .cs_base_o(cs_base_o), .ip_o(ip_o), .evt_mask_o(evt_mask_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    halt_req = 0; mwait_req = 0; mwait_ign_if = 0; park_req = 0;
    intr_pend = 0; lapic_pend = 0; nmi_pend = 0; smi_pend = 0; init_pend = 0;
    if_flag = 0; sipi_valid = 0;
  endtask

  // Drive a request for one cycle; check the state at the following negedge.
  task automatic enter(logic [2:0] kind);
    @(negedge clk);
    clear_inputs();
    case (kind)
      3'd1: halt_req = 1;
      3'd2: park_req = 1;
      3'd3: mwait_req = 1;
      default: begin mwait_req = 1; mwait_ign_if = 1; end
    endcase
    @(negedge clk);
    clear_inputs();
    check("R2 entry state", {29'd0, state_o}, {29'd0, kind});
  endtask

  task automatic send_sipi(logic [7:0] v);
    sipi_valid = 1; sipi_vector = v;
    @(negedge clk);
    sipi_valid = 0;
  endtask

  // Fields: kind[10:8] intr lapic nmi smi init iff exp_wake exp_mr
  localparam logic [10:0] VECS [16] = '{
    {3'd1, 6'b100001, 2'b10},  // HLT  intr IF=1    R4
    {3'd1, 6'b100000, 2'b00},  // HLT  intr IF=0    R4
    {3'd1, 6'b010001, 2'b10},  // HLT  lapic IF=1   R4
    {3'd1, 6'b010000, 2'b00},  // HLT  lapic IF=0   R4
    {3'd1, 6'b001000, 2'b10},  // HLT  nmi          R6
    {3'd1, 6'b000100, 2'b10},  // HLT  smi          R6
    {3'd1, 6'b000010, 2'b10},  // HLT  init         R6
    {3'd3, 6'b100000, 2'b00},  // MWAIT intr IF=0   R4
    {3'd3, 6'b100001, 2'b11},  // MWAIT intr IF=1   R4 R8
    {3'd3, 6'b000100, 2'b11},  // MWAIT smi         R6 R8
    {3'd4, 6'b100000, 2'b11},  // MWAIT_IF intr     R5
    {3'd4, 6'b010000, 2'b11},  // MWAIT_IF lapic    R5
    {3'd4, 6'b000000, 2'b00},  // MWAIT_IF idle
    {3'd2, 6'b111111, 2'b00},  // PARK all events   R9
    {3'd2, 6'b001000, 2'b00},  // PARK nmi          R9
    {3'd1, 6'b000001, 2'b00}   // HLT idle
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 state", {29'd0, state_o}, 32'd0);
    check("R1 mask", {29'd0, evt_mask_o}, 32'd0);
    check("R1 pulses", {29'd0, wake_o, mon_reset_o, start_load_o}, 32'd0);
    check("R1 cs_base", cs_base_o, exp_cs);
    check("R1 ip", ip_o, exp_ip);

    // R11: startup message while ACTIVE is ignored
    send_sipi(8'h55);
    check("R11 cs_base", cs_base_o, exp_cs);
    check("R11 ip", ip_o, exp_ip);
    check("R11 start", {31'd0, start_load_o}, 32'd0);
    check("R11 state", {29'd0, state_o}, 32'd0);

    for (int i = 0; i < 16; i++) begin
      logic [10:0] v;
      logic [2:0]  k;
      v = VECS[i];
      k = v[10:8];
      enter(k);
      if (k == 3'd2) check("R12 mask set", {29'd0, evt_mask_o}, 32'd7);
      {intr_pend, lapic_pend, nmi_pend, smi_pend, init_pend, if_flag} = v[7:2];
      @(negedge clk);
      clear_inputs();
      check($sformatf("R7 wake vec%0d", i), {31'd0, wake_o}, {31'd0, v[1]});
      check($sformatf("R8 monrst vec%0d", i), {31'd0, mon_reset_o}, {31'd0, v[0]});
      check($sformatf("R7 state vec%0d", i), {29'd0, state_o},
            v[1] ? 32'd0 : {29'd0, k});
      if (v[1]) begin
        @(negedge clk);
        check("R7 wake one cycle", {31'd0, wake_o}, 32'd0);
      end else if (k == 3'd2) begin
        send_sipi(8'(i));
        exp_cs = 32'(i) << 8; exp_ip = 0;
        check("R10 state", {29'd0, state_o}, 32'd0);
        check("R10 cs_base", cs_base_o, exp_cs);
        check("R10 ip", ip_o, exp_ip);
        check("R10 start", {31'd0, start_load_o}, 32'd1);
        check("R10 no wake", {31'd0, wake_o}, 32'd0);
        check("R10 mask clear", {29'd0, evt_mask_o}, 32'd0);
      end else begin
        nmi_pend = 1;
        @(negedge clk);
        clear_inputs();
        check("R6 recover", {29'd0, state_o}, 32'd0);
      end
    end

    // R2 priority: park beats halt beats monitor-wait
    @(negedge clk);
    park_req = 1; halt_req = 1; mwait_req = 1;
    @(negedge clk);
    clear_inputs();
    check("R2 park priority", {29'd0, state_o}, 32'd2);
    send_sipi(8'hFF);
    exp_cs = 32'h0000_FF00;
    check("R10 vector FF", cs_base_o, exp_cs);
    halt_req = 1; mwait_req = 1; mwait_ign_if = 1;
    @(negedge clk);
    clear_inputs();
    check("R2 halt priority", {29'd0, state_o}, 32'd1);

    // R3: requests while HLT are ignored
    park_req = 1; mwait_req = 1;
    @(negedge clk);
    @(negedge clk);
    clear_inputs();
    check("R3 ignore requests", {29'd0, state_o}, 32'd1);
    check("R3 mask unchanged", {29'd0, evt_mask_o}, 32'd0);
    // R11: startup message while HLT is ignored
    send_sipi(8'h12);
    check("R11 in HLT state", {29'd0, state_o}, 32'd1);
    check("R11 in HLT cs", cs_base_o, exp_cs);
    init_pend = 1;
    @(negedge clk);
    clear_inputs();
    check("R6 init wake", {31'd0, wake_o}, 32'd1);
    check("R8 no monrst from HLT", {31'd0, mon_reset_o}, 32'd0);

    // R10 vector 0 boundary
    enter(3'd2);
    send_sipi(8'h00);
    check("R10 vector 0", cs_base_o, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule